// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold Flags and Timed Flush

This block holds the transmit and receive byte queues of a serial bus master. Software places outgoing bytes into the transmit queue through a data write strobe, and the serial engine drains them through a valid/ready output. On the receive side, the engine offers incoming bytes through a valid/ready input, and software removes them through a read strobe. The read data is the oldest entry, presented ahead of the strobe.

Each queue is 16 bytes deep. Each has a 4-bit threshold register that resets to 0. The queues report empty and full flags and a threshold flag. The transmit threshold flag means nearly empty. The receive threshold flag means nearly full. Each queue also has a sticky overrun flag. A flush clears a queue, and it is started by setting a bit in the control word. For each lane, a small state machine has two states, `FL_IDLE` and `FL_DRAIN`. A control write with that lane's flush bit takes the lane from `FL_IDLE` to `FL_DRAIN`. The lane stays in `FL_DRAIN` for four cycles. On the last of those cycles it returns to `FL_IDLE`, and at the same moment it zeroes both pointers and clears the overrun flag. The control read-back shows a flush bit as 1 for as long as that lane is in `FL_DRAIN`.

Top module: `byte_fifo_pair`

## Requirements
- R1: Bytes written with `tx_wr_en` leave on `tx_out_data` in write order. A byte is removed on each cycle where `tx_out_valid` and `tx_out_ready` are both high.
- R2: Bytes accepted on `rx_in_valid && rx_in_ready` are read on `rx_rd_data` in arrival order. Each `rx_rd_en` pulse advances to the next byte.
- R3: Each queue holds 16 entries. The empty flag is high at 0 entries and the full flag is high at 16 entries.
- R4: `tx_nempty` is high exactly when the TX entry count is less than or equal to the TX threshold.
- R5: `rx_nfull` is high exactly when the RX entry count is greater than or equal to the RX threshold.
- R6: Both thresholds are 4 bits wide, with a largest value of 15. Both reset to 0. With thresholds at 0 and both queues empty, `tx_nempty` and `rx_nfull` are both high.
- R7: A TX write while the TX queue is full is dropped and leaves the stored bytes unchanged. It sets the sticky `tx_ovr` flag. A TX flush clears `tx_ovr`.
- R8: `rx_in_ready` is low while the RX queue is full. An offer made while the queue is full is not stored and sets the sticky `rx_ovr` flag. An RX flush clears `rx_ovr`.
- R9: Writing `ctl_wdata` bit 7 flushes TX and bit 8 flushes RX. Both bits may be set in one write. The matching bit of `ctl_rdata` reads 1 for exactly 4 cycles after the write edge, then 0, and the queue is then empty. The other queue is not touched.
- R10: While a lane is flushing, pushes and pops on that lane are ignored. `tx_out_valid` is low during a TX flush, and `rx_in_ready` is low during an RX flush.
- R11: After reset both queues are empty, no flush is pending, both overrun flags are low, `tx_out_valid` is low and `rx_in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 2 | Flush request bits, positions 8:7 (bit 8 RX, bit 7 TX) |
| ctl_rdata | output | 2 | Flush pending bits, positions 8:7 |
| tx_thr_we | input | 1 | TX threshold write strobe |
| tx_thr_wdata | input | 4 | TX threshold value |
| rx_thr_we | input | 1 | RX threshold write strobe |
| rx_thr_wdata | input | 4 | RX threshold value |
| tx_wr_en | input | 1 | Software TX data write strobe |
| tx_wr_data | input | 8 | Software TX data byte |
| rx_rd_en | input | 1 | Software RX data read strobe |
| rx_rd_data | output | 8 | Oldest RX byte |
| tx_out_valid | output | 1 | TX byte available to the engine |
| tx_out_ready | input | 1 | Engine takes the TX byte |
| tx_out_data | output | 8 | TX byte to the engine |
| rx_in_valid | input | 1 | Engine offers an RX byte |
| rx_in_ready | output | 1 | RX byte can be accepted |
| rx_in_data | input | 8 | RX byte from the engine |
| tx_empty | output | 1 | TX queue empty |
| tx_nempty | output | 1 | TX count at or below its threshold |
| tx_full | output | 1 | TX queue full |
| tx_ovr | output | 1 | Sticky TX overrun |
| rx_empty | output | 1 | RX queue empty |
| rx_nfull | output | 1 | RX count at or above its threshold |
| rx_full | output | 1 | RX queue full |
| rx_ovr | output | 1 | Sticky RX overrun |

## Verification
A table of threshold and fill-level pairs is applied to each queue. The pairs are chosen so that the counts sit just below, exactly at and just above the threshold, and at 0 and 16. This separates `<=` from `<` and `>=` from `>`, and it shows whether the empty and full boundaries sit at the right count. Byte-order tests use distinct values on each side, so a wrong pointer or a wrong head is caught. The overrun tests fill a queue, then offer one more byte with a marker value. Draining all 16 entries afterwards shows whether the marker got in. The flush tests count the cycles the pending bit stays high. They also push during the flush, and they flush one lane alone so that any spill onto the other lane shows.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
    typedef enum logic [0:0] {
        FL_IDLE  = 1'b0,
        FL_DRAIN = 1'b1
    } flush_state_e;

    localparam int CTL_TX_FLUSH_BIT = 7;
    localparam int CTL_RX_FLUSH_BIT = 8;
endpackage

// File: rtl/bfp_flush_fsm.sv
module bfp_flush_fsm #(
    parameter int FLUSH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy,
    output logic done
);
    import bfp_pkg::*;

    localparam int CNT_W = $clog2(FLUSH_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FLUSH_CYC - 1);

    flush_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FL_IDLE: begin
                if (req) begin
                    state_d = FL_DRAIN;
                    cnt_d   = '0;
                end
            end
            FL_DRAIN: begin
                if (cnt_q == LAST) begin
                    state_d = FL_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == FL_DRAIN);
        done = (state_q == FL_DRAIN) && (cnt_q == LAST);
    end

    // R9: the pending indication ends only after the full drain length
    p_flush_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt_q) == LAST));

    // R9: a drain starts only on a request
    p_flush_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req));
endmodule

// File: rtl/bfp_store.sv
module bfp_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]   mem [DEPTH];
    logic [PTR_W:0] wp_q, rp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else if (clear) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear) mem[wp_q[PTR_W-1:0]] <= push_data;
    end

    always_comb begin
        count = wp_q - rp_q;
        head  = mem[rp_q[PTR_W-1:0]];
    end

    // R3: occupancy never exceeds the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (PTR_W+1)'(DEPTH));
endmodule

// File: rtl/bfp_lane.sv
module bfp_lane #(
    parameter int W         = 8,
    parameter int DEPTH     = 16,
    parameter int THR_W     = 4,
    parameter int FLUSH_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_req,
    input  logic             push_req,
    input  logic [W-1:0]     push_data,
    input  logic             pop_req,
    input  logic [THR_W-1:0] thr,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             full,
    output logic             at_or_below,
    output logic             at_or_above,
    output logic             busy,
    output logic             ovr
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic             done;
    logic             push_ok, pop_ok, push_drop;
    logic [CNT_W-1:0] count;

    bfp_flush_fsm #(.FLUSH_CYC(FLUSH_CYC)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (flush_req),
        .busy  (busy),
        .done  (done)
    );

    bfp_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (done),
        .push      (push_ok),
        .push_data (push_data),
        .pop       (pop_ok),
        .head      (head),
        .count     (count)
    );

    always_comb begin
        empty       = (count == '0);
        full        = (count == CNT_W'(DEPTH));
        push_ok     = push_req && !full && !busy;
        push_drop   = push_req && full && !busy;
        pop_ok      = pop_req && !empty && !busy;
        at_or_below = (count <= CNT_W'(thr));
        at_or_above = (count >= CNT_W'(thr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ovr <= 1'b0;
        else if (done)      ovr <= 1'b0;
        else if (push_drop) ovr <= 1'b1;
    end

    // R7/R8: a push into a full queue leaves the occupancy unchanged
    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_drop && !pop_ok) |=> $stable(count));

    // R7/R8: overrun rises only after a push offered while full
    p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(push_req && full && !busy));

    // R9: the queue is empty once a flush ends
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> empty);

    // R10: the occupancy is frozen while a flush is in progress
    p_frozen_in_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(count));
endmodule

// File: rtl/byte_fifo_pair.sv
module byte_fifo_pair #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int THR_W     = 4,
    parameter int FLUSH_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [8:7]        ctl_wdata,
    output logic [8:7]        ctl_rdata,
    input  logic              tx_thr_we,
    input  logic [THR_W-1:0]  tx_thr_wdata,
    input  logic              rx_thr_we,
    input  logic [THR_W-1:0]  rx_thr_wdata,
    input  logic              tx_wr_en,
    input  logic [DATA_W-1:0] tx_wr_data,
    input  logic              rx_rd_en,
    output logic [DATA_W-1:0] rx_rd_data,
    output logic              tx_out_valid,
    input  logic              tx_out_ready,
    output logic [DATA_W-1:0] tx_out_data,
    input  logic              rx_in_valid,
    output logic              rx_in_ready,
    input  logic [DATA_W-1:0] rx_in_data,
    output logic              tx_empty,
    output logic              tx_nempty,
    output logic              tx_full,
    output logic              tx_ovr,
    output logic              rx_empty,
    output logic              rx_nfull,
    output logic              rx_full,
    output logic              rx_ovr
);
    import bfp_pkg::*;

    localparam int NLANE = 2;
    localparam int TX = 0;
    localparam int RX = 1;

    logic [THR_W-1:0]  thr_q   [NLANE];
    logic [NLANE-1:0]  flush_req, push_req, pop_req;
    logic [DATA_W-1:0] push_data [NLANE];
    logic [DATA_W-1:0] head      [NLANE];
    logic [NLANE-1:0]  empty, full, below, above, busy, ovr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q[TX] <= '0;
            thr_q[RX] <= '0;
        end else begin
            if (tx_thr_we) thr_q[TX] <= tx_thr_wdata;
            if (rx_thr_we) thr_q[RX] <= rx_thr_wdata;
        end
    end

    always_comb begin
        flush_req[TX] = ctl_we && ctl_wdata[CTL_TX_FLUSH_BIT];
        flush_req[RX] = ctl_we && ctl_wdata[CTL_RX_FLUSH_BIT];
        push_req[TX]  = tx_wr_en;
        push_data[TX] = tx_wr_data;
        pop_req[TX]   = tx_out_ready;
        push_req[RX]  = rx_in_valid;
        push_data[RX] = rx_in_data;
        pop_req[RX]   = rx_rd_en;
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        bfp_lane #(
            .W(DATA_W), .DEPTH(DEPTH), .THR_W(THR_W), .FLUSH_CYC(FLUSH_CYC)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush_req   (flush_req[g]),
            .push_req    (push_req[g]),
            .push_data   (push_data[g]),
            .pop_req     (pop_req[g]),
            .thr         (thr_q[g]),
            .head        (head[g]),
            .empty       (empty[g]),
            .full        (full[g]),
            .at_or_below (below[g]),
            .at_or_above (above[g]),
            .busy        (busy[g]),
            .ovr         (ovr[g])
        );
    end

    always_comb begin
        ctl_rdata[CTL_TX_FLUSH_BIT] = busy[TX];
        ctl_rdata[CTL_RX_FLUSH_BIT] = busy[RX];
        tx_out_valid = !empty[TX] && !busy[TX];
        tx_out_data  = head[TX];
        rx_in_ready  = !full[RX] && !busy[RX];
        rx_rd_data   = head[RX];
        tx_empty     = empty[TX];
        tx_nempty    = below[TX];
        tx_full      = full[TX];
        tx_ovr       = ovr[TX];
        rx_empty     = empty[RX];
        rx_nfull     = above[RX];
        rx_full      = full[RX];
        rx_ovr       = ovr[RX];
    end

    // R10: the engine never sees a TX byte during a TX flush
    p_no_tx_in_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CTL_TX_FLUSH_BIT] |-> !tx_out_valid);

    // R8: no RX byte is accepted while the RX queue is full
    p_rx_ready_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_in_ready);
endmodule

// File: tb/byte_fifo_pair_tb_top.sv
module byte_fifo_pair_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [8:7] ctl_wdata = '0;
    logic [8:7] ctl_rdata;
    logic       tx_thr_we = 1'b0, rx_thr_we = 1'b0;
    logic [3:0] tx_thr_wdata = '0, rx_thr_wdata = '0;
    logic       tx_wr_en = 1'b0;
    logic [7:0] tx_wr_data = '0;
    logic       rx_rd_en = 1'b0;
    logic [7:0] rx_rd_data;
    logic       tx_out_valid, tx_out_ready = 1'b0;
    logic [7:0] tx_out_data;
    logic       rx_in_valid = 1'b0, rx_in_ready;
    logic [7:0] rx_in_data = '0;
    logic       tx_empty, tx_nempty, tx_full, tx_ovr;
    logic       rx_empty, rx_nfull, rx_full, rx_ovr;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    byte_fifo_pair dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .tx_thr_we(tx_thr_we), .tx_thr_wdata(tx_thr_wdata),
        .rx_thr_we(rx_thr_we), .rx_thr_wdata(rx_thr_wdata),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
        .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
        .tx_empty(tx_empty), .tx_nempty(tx_nempty), .tx_full(tx_full), .tx_ovr(tx_ovr),
        .rx_empty(rx_empty), .rx_nfull(rx_nfull), .rx_full(rx_full), .rx_ovr(rx_ovr)
    );

    // lane 0 = TX, 1 = RX; e_lvl is tx_nempty or rx_nfull
    typedef struct packed {
        logic       lane;
        logic [3:0] thr;
        logic [4:0] n;
        logic       e_empty;
        logic       e_lvl;
        logic       e_full;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0,  5'd0,  1'b1, 1'b1, 1'b0},
        '{1'b0, 4'd3,  5'd3,  1'b0, 1'b1, 1'b0},
        '{1'b0, 4'd3,  5'd4,  1'b0, 1'b0, 1'b0},
        '{1'b0, 4'd8,  5'd1,  1'b0, 1'b1, 1'b0},
        '{1'b0, 4'd15, 5'd15, 1'b0, 1'b1, 1'b0},
        '{1'b0, 4'd15, 5'd16, 1'b0, 1'b0, 1'b1},
        '{1'b1, 4'd0,  5'd0,  1'b1, 1'b1, 1'b0},
        '{1'b1, 4'd5,  5'd4,  1'b0, 1'b0, 1'b0},
        '{1'b1, 4'd5,  5'd5,  1'b0, 1'b1, 1'b0},
        '{1'b1, 4'd15, 5'd16, 1'b0, 1'b1, 1'b1},
        '{1'b1, 4'd1,  5'd0,  1'b1, 1'b0, 1'b0}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_wr_en = 1'b1; tx_wr_data = b;
        step();
        tx_wr_en = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_in_valid = 1'b1; rx_in_data = b;
        step();
        rx_in_valid = 1'b0;
    endtask

    task automatic flush(input logic [8:7] bits);
        ctl_we = 1'b1; ctl_wdata = bits;
        step();
        ctl_we = 1'b0; ctl_wdata = '0;
        repeat (4) step();
    endtask

    task automatic set_thr(input logic lane, input logic [3:0] v);
        if (lane) begin rx_thr_we = 1'b1; rx_thr_wdata = v; end
        else      begin tx_thr_we = 1'b1; tx_thr_wdata = v; end
        step();
        tx_thr_we = 1'b0; rx_thr_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();

        // R11 / R6: reset state; thresholds at 0 make both level flags high
        chk("R11 tx_empty", tx_empty, 1);
        chk("R11 rx_empty", rx_empty, 1);
        chk("R11 tx_full", tx_full, 0);
        chk("R11 ovr", {tx_ovr, rx_ovr}, 0);
        chk("R11 ctl_rdata", ctl_rdata, 0);
        chk("R11 tx_out_valid", tx_out_valid, 0);
        chk("R11 rx_in_ready", rx_in_ready, 1);
        chk("R6 tx_nempty reset thr", tx_nempty, 1);
        chk("R6 rx_nfull reset thr", rx_nfull, 1);

        // Vector table: R3 / R4 / R5 threshold and boundary flags
        for (int i = 0; i < NV; i++) begin
            flush(2'b11);
            set_thr(VECS[i].lane, VECS[i].thr);
            for (int k = 0; k < int'(VECS[i].n); k++) begin
                if (VECS[i].lane) push_rx(8'(k)); else push_tx(8'(k));
            end
            if (!VECS[i].lane) begin
                chk("R3 tx_empty vec", tx_empty, VECS[i].e_empty);
                chk("R4 tx_nempty vec", tx_nempty, VECS[i].e_lvl);
                chk("R3 tx_full vec", tx_full, VECS[i].e_full);
            end else begin
                chk("R3 rx_empty vec", rx_empty, VECS[i].e_empty);
                chk("R5 rx_nfull vec", rx_nfull, VECS[i].e_lvl);
                chk("R3 rx_full vec", rx_full, VECS[i].e_full);
            end
        end
        flush(2'b11);

        // R1: TX order through valid/ready
        push_tx(8'hA1); push_tx(8'hB2); push_tx(8'hC3);
        tx_out_ready = 1'b1;
        chk("R1 valid", tx_out_valid, 1);
        chk("R1 byte0", tx_out_data, 8'hA1);
        step();
        chk("R1 byte1", tx_out_data, 8'hB2);
        step();
        chk("R1 byte2", tx_out_data, 8'hC3);
        step();
        tx_out_ready = 1'b0;
        chk("R1 drained", tx_out_valid, 0);

        // R2: RX order through read strobe
        push_rx(8'h5A); push_rx(8'h6B); push_rx(8'h7C);
        chk("R2 byte0", rx_rd_data, 8'h5A);
        rx_rd_en = 1'b1;
        step();
        chk("R2 byte1", rx_rd_data, 8'h6B);
        step();
        chk("R2 byte2", rx_rd_data, 8'h7C);
        step();
        rx_rd_en = 1'b0;
        chk("R2 drained", rx_empty, 1);

        // R7: TX write while full is dropped, overrun set, cleared by TX flush
        for (int k = 0; k < 16; k++) push_tx(8'(k * 7 + 1));
        chk("R7 full", tx_full, 1);
        chk("R7 ovr before", tx_ovr, 0);
        push_tx(8'hEE);
        chk("R7 ovr set", tx_ovr, 1);
        tx_out_ready = 1'b1;
        for (int k = 0; k < 16; k++) begin
            chk("R7 contents", tx_out_data, 8'(k * 7 + 1));
            step();
        end
        tx_out_ready = 1'b0;
        chk("R7 no extra byte", tx_empty, 1);
        chk("R7 ovr sticky", tx_ovr, 1);
        flush(2'b01);
        chk("R7 ovr cleared", tx_ovr, 0);

        // R8: RX offer while full refused, overrun set, cleared by RX flush
        for (int k = 0; k < 16; k++) push_rx(8'(k + 8'h40));
        chk("R8 ready low", rx_in_ready, 0);
        push_rx(8'hEE);
        chk("R8 ovr set", rx_ovr, 1);
        rx_rd_en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            chk("R8 contents", rx_rd_data, 8'(k + 8'h40));
            step();
        end
        rx_rd_en = 1'b0;
        chk("R8 no extra byte", rx_empty, 1);
        flush(2'b10);
        chk("R8 ovr cleared", rx_ovr, 0);

        // R9 / R10: joint flush lasts 4 cycles, pushes during it ignored
        push_tx(8'h11); push_tx(8'h22); push_rx(8'h33);
        ctl_we = 1'b1; ctl_wdata = 2'b11;
        step();
        ctl_we = 1'b0; ctl_wdata = '0;
        for (int k = 0; k < 4; k++) begin
            chk("R9 pending", ctl_rdata, 2'b11);
            if (k == 1) begin
                chk("R10 tx_out_valid low", tx_out_valid, 0);
                chk("R10 rx_in_ready low", rx_in_ready, 0);
                tx_wr_en = 1'b1; tx_wr_data = 8'h99;
                rx_in_valid = 1'b1; rx_in_data = 8'h98;
            end
            step();
            tx_wr_en = 1'b0; rx_in_valid = 1'b0;
        end
        chk("R9 pending cleared", ctl_rdata, 2'b00);
        chk("R9 tx emptied", tx_empty, 1);
        chk("R10 rx push ignored", rx_empty, 1);

        // R9: TX-only flush leaves RX untouched
        push_tx(8'h44); push_rx(8'h55);
        ctl_we = 1'b1; ctl_wdata = 2'b01;
        step();
        ctl_we = 1'b0; ctl_wdata = '0;
        chk("R9 tx only pending", ctl_rdata, 2'b01);
        repeat (4) step();
        chk("R9 tx only done", ctl_rdata, 2'b00);
        chk("R9 tx only emptied", tx_empty, 1);
        chk("R9 rx kept", rx_rd_data, 8'h55);
        chk("R9 rx not empty", rx_empty, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule